// File: doc/BRIEF.md
# Next-PC Controller with Execute-One Redirect

This block owns the program counter of a word-addressed 16-bit core and decides, once per clock, where the next instruction is fetched from. The decode logic presents the class of the instruction at the current PC, together with the branch condition field, the status flags, one register operand and the two relative offsets. From these the block chooses one of four next addresses: the following word, a flag-conditional relative branch target, a jump-and-link target, or a register-supplied jump address. All address arithmetic wraps modulo 2^16. For jump-and-link it also drives the return value and a write strobe for the return register.

The block also handles an execute-one instruction. That instruction sends a single fetch to a register-supplied address and records the word after itself as a resume address. The block then spends exactly one cycle in a borrowed state. In that cycle the remote instruction runs, any PC change it asks for is thrown away, and the PC returns to the resume address. A `borrowed` output marks that cycle so that the rest of the core can hold back side effects that belong only to control flow.

The controller is a two-state machine. RUN is the normal state, entered from reset. RUN goes to BORROW on an execute-one instruction (transition EXEC_ENTER). BORROW always returns to RUN on the next clock (transition RESUME). A synchronous reset puts the machine in RUN with the PC at zero from any state.

Top module: `npc_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the PC becomes 0x0000 and the state becomes RUN, so `borrowed` is low afterwards. This applies even in the middle of an execute-one sequence.
- R2: In RUN, class code 000 (sequential) and the unused codes 101, 110 and 111 load PC+1.
- R3: A branch (class 001) is taken when its condition holds. Condition 000 needs Z=1. Condition 001 needs Z=0. Condition 010 needs Z=0 and N=0. Condition 011 needs N=1. Condition 100 needs Z=1, or Z=0 with N=0. Condition 101 needs N=1 or Z=1. Condition 110 needs V=1. Condition 111 is always taken.
- R4: A taken branch loads PC+1 plus the sign-extended 8-bit `br_ofs`. A branch that is not taken loads PC+1.
- R5: Jump-and-link (class 010) loads PC+1 plus the sign-extended 12-bit `jal_ofs`. In the same cycle it raises `link_we` and drives `link_data` = PC+1.
- R6: Jump-register (class 011) loads the full 16-bit `reg_val`.
- R7: Execute-one (class 100) in RUN loads `reg_val` into the PC, and `borrowed` is high for the following cycle.
- R8: In the borrowed cycle the PC is loaded with the execute instruction's address plus one, whatever the class or operands presented. `borrowed` is never high for two cycles in a row.
- R9: `link_we` is high only in RUN with class 010. In particular it is low while `borrowed` is high.
- R10: All relative targets and PC+1 wrap modulo 2^16. For example, a taken branch at PC 0x0000 with offset 0x80 lands at 0xFF81.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_cls | input | 3 | Class of the instruction at `pc`: 000 seq, 001 branch, 010 jump-and-link, 011 jump-register, 100 execute-one |
| br_cond | input | 3 | Branch condition code |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Sign flag |
| flag_v | input | 1 | Overflow flag |
| reg_val | input | 16 | Register operand for jump-register and execute-one |
| br_ofs | input | 8 | Signed branch offset |
| jal_ofs | input | 12 | Signed jump-and-link offset |
| pc | output | 16 | Current fetch address |
| link_data | output | 16 | Return address (PC+1) |
| link_we | output | 1 | Write strobe for the return register |
| borrowed | output | 1 | High while a borrowed instruction executes |

## Verification
The embedded properties check on every cycle that the borrowed state never lasts two cycles, that it always resumes at the execute address plus one, and that the link strobe is held back while it lasts. They also check the sequential, jump-register and execute-entry targets, the link value, and the return to zero after reset. Only the bench scenarios cover the full table of branch conditions against every flag combination and the wrap of negative offsets around address zero. The bench scenarios also cover borrowed instructions that are themselves jumps or execute-one, and a reset that arrives during the borrowed cycle.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [2:0] {
        CLS_SEQ    = 3'b000,
        CLS_BRANCH = 3'b001,
        CLS_JAL    = 3'b010,
        CLS_JR     = 3'b011,
        CLS_EXEC   = 3'b100,
        CLS_RSV5   = 3'b101,
        CLS_RSV6   = 3'b110,
        CLS_RSV7   = 3'b111
    } npc_cls_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_BORROW = 1'b1
    } npc_state_e;

endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval #(
    parameter int COND_W = 3
) (
    input  logic [COND_W-1:0] cond,
    input  logic              z,
    input  logic              n,
    input  logic              v,
    output logic              take
);
    localparam int NCOND = 1 << COND_W;

    logic [NCOND-1:0] hit;

    // one result per condition code; the selected one decides the branch
    always_comb begin
        hit    = '0;
        hit[0] = z;
        hit[1] = !z;
        hit[2] = !z && !n;
        hit[3] = n;
        hit[4] = z || (!z && !n);
        hit[5] = n || z;
        hit[6] = v;
        hit[7] = 1'b1;
    end

    assign take = hit[cond];

endmodule

// File: rtl/npc_target_calc.sv
module npc_target_calc #(
    parameter int ADDR_W = 16,
    parameter int BOFS_W = 8,
    parameter int JOFS_W = 12
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [BOFS_W-1:0] br_ofs,
    input  logic [JOFS_W-1:0] jal_ofs,
    output logic [ADDR_W-1:0] pc_inc,
    output logic [ADDR_W-1:0] br_tgt,
    output logic [ADDR_W-1:0] jal_tgt
);
    localparam int BEXT = ADDR_W - BOFS_W;
    localparam int JEXT = ADDR_W - JOFS_W;
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] br_sx;
    logic [ADDR_W-1:0] jal_sx;

    assign br_sx   = {{BEXT{br_ofs[BOFS_W-1]}}, br_ofs};
    assign jal_sx  = {{JEXT{jal_ofs[JOFS_W-1]}}, jal_ofs};

    // all sums truncate to ADDR_W bits, giving modulo wrap
    assign pc_inc  = pc + ONE;
    assign br_tgt  = pc_inc + br_sx;
    assign jal_tgt = pc_inc + jal_sx;

endmodule

// File: rtl/npc_fsm.sv
module npc_fsm
    import npc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  npc_cls_e          cls,
    input  logic              take,
    input  logic [ADDR_W-1:0] reg_val,
    input  logic [ADDR_W-1:0] pc_inc,
    input  logic [ADDR_W-1:0] br_tgt,
    input  logic [ADDR_W-1:0] jal_tgt,
    output logic [ADDR_W-1:0] pc,
    output logic              borrowed,
    output logic              link_we
);
    npc_state_e        state_q, state_nx;
    logic [ADDR_W-1:0] pc_q, pc_nx;
    logic [ADDR_W-1:0] resume_q, resume_nx;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_RUN;
            pc_q     <= '0;
            resume_q <= '0;
        end else begin
            state_q  <= state_nx;
            pc_q     <= pc_nx;
            resume_q <= resume_nx;
        end
    end

    // next state and next PC
    always_comb begin
        state_nx  = state_q;
        pc_nx     = pc_inc;
        resume_nx = resume_q;
        unique case (state_q)
            ST_RUN: begin
                unique case (cls)
                    CLS_BRANCH: if (take) pc_nx = br_tgt;
                    CLS_JAL:    pc_nx = jal_tgt;
                    CLS_JR:     pc_nx = reg_val;
                    CLS_EXEC: begin
                        pc_nx     = reg_val;
                        resume_nx = pc_inc;
                        state_nx  = ST_BORROW;
                    end
                    default:    pc_nx = pc_inc;
                endcase
            end
            ST_BORROW: begin
                pc_nx    = resume_q;
                state_nx = ST_RUN;
            end
        endcase
    end

    // outputs
    always_comb begin
        borrowed = (state_q == ST_BORROW);
        link_we  = (state_q == ST_RUN) && (cls == CLS_JAL);
        pc       = pc_q;
    end

    AST_ONE_BORROW: assert property (@(posedge clk) disable iff (rst)
        borrowed |=> !borrowed);                                         // R8
    AST_RESUME_ADDR: assert property (@(posedge clk) disable iff (rst)
        (!borrowed && cls == CLS_EXEC) |=> ##1 (pc == $past(pc_inc, 2))); // R8
    AST_LINK_GATED: assert property (@(posedge clk) disable iff (rst)
        borrowed |-> !link_we);                                          // R9

endmodule

// File: rtl/npc_ctrl.sv
module npc_ctrl
    import npc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int COND_W = 3,
    parameter int BOFS_W = 8,
    parameter int JOFS_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        instr_cls,
    input  logic [COND_W-1:0] br_cond,
    input  logic              flag_z,
    input  logic              flag_n,
    input  logic              flag_v,
    input  logic [ADDR_W-1:0] reg_val,
    input  logic [BOFS_W-1:0] br_ofs,
    input  logic [JOFS_W-1:0] jal_ofs,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] link_data,
    output logic              link_we,
    output logic              borrowed
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    npc_cls_e          cls;
    logic              take;
    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] br_tgt;
    logic [ADDR_W-1:0] jal_tgt;

    assign cls       = npc_cls_e'(instr_cls);
    assign link_data = pc_inc;

    npc_cond_eval #(.COND_W(COND_W)) u_cond (
        .cond (br_cond),
        .z    (flag_z),
        .n    (flag_n),
        .v    (flag_v),
        .take (take)
    );

    npc_target_calc #(
        .ADDR_W(ADDR_W), .BOFS_W(BOFS_W), .JOFS_W(JOFS_W)
    ) u_tgt (
        .pc      (pc),
        .br_ofs  (br_ofs),
        .jal_ofs (jal_ofs),
        .pc_inc  (pc_inc),
        .br_tgt  (br_tgt),
        .jal_tgt (jal_tgt)
    );

    npc_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cls      (cls),
        .take     (take),
        .reg_val  (reg_val),
        .pc_inc   (pc_inc),
        .br_tgt   (br_tgt),
        .jal_tgt  (jal_tgt),
        .pc       (pc),
        .borrowed (borrowed),
        .link_we  (link_we)
    );

    AST_RESET_PC: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == '0 && !borrowed));                          // R1
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (!borrowed && instr_cls == CLS_SEQ) |=> (pc == $past(pc) + ONE)); // R2
    AST_JR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!borrowed && instr_cls == CLS_JR) |=> (pc == $past(reg_val)));   // R6
    AST_EXEC_ENTER: assert property (@(posedge clk) disable iff (rst)
        (!borrowed && instr_cls == CLS_EXEC) |=> (borrowed && pc == $past(reg_val))); // R7
    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_data == pc + ONE));                             // R5

endmodule

// File: tb/npc_ctrl_bench.sv
`timescale 1ns/1ps
module npc_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  instr_cls = '0;
    logic [2:0]  br_cond = '0;
    logic        flag_z = 1'b0, flag_n = 1'b0, flag_v = 1'b0;
    logic [15:0] reg_val = '0;
    logic [7:0]  br_ofs = '0;
    logic [11:0] jal_ofs = '0;
    logic [15:0] pc, link_data;
    logic        link_we, borrowed;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] m_pc = '0;
    logic [15:0] m_resume = '0;
    bit          m_borrow = 1'b0;

    always #2 clk = ~clk;

    npc_ctrl u_npc_ctrl (
        .clk(clk), .rst(rst), .instr_cls(instr_cls), .br_cond(br_cond),
        .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v), .reg_val(reg_val),
        .br_ofs(br_ofs), .jal_ofs(jal_ofs), .pc(pc), .link_data(link_data),
        .link_we(link_we), .borrowed(borrowed)
    );

    function automatic bit cond_ok(input logic [2:0] c, input logic z, n, v);
        case (c)
            3'd0: return z;
            3'd1: return !z;
            3'd2: return !z && !n;
            3'd3: return n;
            3'd4: return z || (!z && !n);
            3'd5: return n || z;
            3'd6: return v;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [15:0] exp_next(input logic [2:0] c, input logic [2:0] cd,
                                             input logic z, n, v, input logic [15:0] rv,
                                             input logic [7:0] b, input logic [11:0] j);
        logic [15:0] inc;
        inc = m_pc + 16'd1;
        if (m_borrow) return m_resume;
        case (c)
            3'd1: return cond_ok(cd, z, n, v) ? inc + {{8{b[7]}}, b} : inc;
            3'd2: return inc + {{4{j[11]}}, j};
            3'd3: return rv;
            3'd4: return rv;
            default: return inc;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // one instruction per call; entered and left at a falling edge
    task automatic step(input logic [2:0] c, input logic [2:0] cd, input logic z, n, v,
                        input logic [15:0] rv, input logic [7:0] b, input logic [11:0] j,
                        input string tag);
        logic [15:0] nxt;
        bit exp_lw;
        string t;
        instr_cls = c; br_cond = cd; flag_z = z; flag_n = n; flag_v = v;
        reg_val = rv; br_ofs = b; jal_ofs = j;
        #1;
        exp_lw = !m_borrow && (c == 3'd2);
        chk(link_we == exp_lw, "R9 link strobe", {15'd0, link_we}, {15'd0, exp_lw});
        if (exp_lw) chk(link_data == m_pc + 16'd1, "R5 link value", link_data, m_pc + 16'd1);
        chk(borrowed == m_borrow, "R7 borrowed flag", {15'd0, borrowed}, {15'd0, m_borrow});
        nxt = exp_next(c, cd, z, n, v, rv, b, j);
        if (tag != "") t = tag;
        else if (m_borrow) t = "R8 resume";
        else case (c)
            3'd1: t = "R3/R4 branch";
            3'd2: t = "R5 jal";
            3'd3: t = "R6 jr";
            3'd4: t = "R7 exec";
            default: t = "R2 seq";
        endcase
        if (!m_borrow && c == 3'd4) begin
            m_resume = m_pc + 16'd1;
            m_borrow = 1'b1;
        end else begin
            m_borrow = 1'b0;
        end
        m_pc = nxt;
        @(negedge clk);
        chk(pc == m_pc, t, pc, m_pc);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_pc = '0; m_borrow = 1'b0;
        chk(pc == 16'h0000, "R1 reset pc", pc, 16'h0000);
        chk(borrowed == 1'b0, "R1 reset state", {15'd0, borrowed}, 16'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd552));
        @(negedge clk);
        @(negedge clk);
        do_reset();

        // R10: negative branch offset wraps below zero
        step(3'd1, 3'd7, 0, 0, 0, 16'h0, 8'h80, 12'h0, "R10 wrap");
        // R2: sequential at top of space wraps to 0
        step(3'd3, 3'd0, 0, 0, 0, 16'hFFFF, 8'h0, 12'h0, "R6 jr to top");
        step(3'd0, 3'd0, 0, 0, 0, 16'h0, 8'h0, 12'h0, "R10 seq wrap");
        step(3'd6, 3'd0, 0, 0, 0, 16'h1234, 8'h0, 12'h0, "R2 unused code");

        // R3: every condition against every flag combination
        for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 8; f++) begin
                step(3'd1, 3'(c), f[2], f[1], f[0], 16'h0, 8'h05, 12'h0, "R3 condition");
            end
        end

        // R5: extreme jump-and-link offsets
        step(3'd2, 3'd0, 0, 0, 0, 16'h0, 8'h0, 12'h7FF, "R5 jal max");
        step(3'd2, 3'd0, 0, 0, 0, 16'h0, 8'h0, 12'h800, "R5 jal min");

        // R7/R8: borrowed instruction of every class
        for (int k = 0; k < 8; k++) begin
            step(3'd4, 3'd0, 0, 0, 0, 16'h4000 + 16'(k), 8'h0, 12'h0, "R7 exec enter");
            step(3'(k), 3'd7, 1, 1, 1, 16'hBEEF, 8'h7F, 12'h7FF, "R8 borrowed ignored");
        end
        // R9: borrowed jump-and-link raises no strobe (checked inside step)
        step(3'd4, 3'd0, 0, 0, 0, 16'h2222, 8'h0, 12'h0, "");
        step(3'd2, 3'd0, 0, 0, 0, 16'h0, 8'h0, 12'h100, "R9 borrowed jal");

        // R1: reset during the borrowed cycle
        step(3'd4, 3'd0, 0, 0, 0, 16'h3333, 8'h0, 12'h0, "");
        do_reset();

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] rc;
            rc = 3'($urandom % 8);
            step(rc, 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                 16'($urandom), 8'($urandom), 12'($urandom), "");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule